// File: doc/BRIEF.md
# Reset-Released Boot Image Loader

This block starts an I/O processor without any software. While the processor is held in reset, a maintenance host may fill a large shared buffer memory with a boot image. Releasing the processor from reset starts a fixed-length copy. The block copies the first `2**AW` words of buffer memory into the processor's local memory. Buffer word n lands at local address n.

Reads from buffer memory return data one cycle after the request. The loader keeps one read in flight at all times, so it writes one word to local memory in every cycle of the copy. After the last word is written, the block raises a one-cycle completion interrupt. In the next cycle it pulses a start strobe that lets the processor begin fetching at local address 0. After that it holds a done flag.

Putting the processor back into reset, or applying the chip reset, cancels any copy in progress. The block then returns to idle without issuing an interrupt or a start strobe. With the default width the copy is 65,536 sixteen-bit words, which is 128 KB.

Top module: `boot_loader`

## Requirements
- R1: While `cpu_hold` is 1, the block issues no buffer reads (`buf_rd_en` = 0) and no local writes (`loc_wr_en` = 0). In the same cycles `busy`, `irq` and `start_exec` are 0. From the cycle after `cpu_hold` is first seen high, `done` is also 0.
- R2: A release starts the copy. A release is `cpu_hold` sampled 0 at a clock edge where it was 1 at the previous edge, or `cpu_hold` already 0 at the first edge after chip reset ends. In the cycle after that edge, the read of buffer address 0 is issued and `busy` is 1.
- R3: Exactly `2**AW` words are copied. The word read from buffer address n is written unchanged to local address n, in ascending address order.
- R4: Buffer read data arrives one cycle after the request. The write of word n occurs in the cycle after the read of word n. Writes occur in every cycle from the first word to the last, so the copy takes `2**AW`+1 cycles from the first read to the last write.
- R5: `irq` is a single-cycle pulse in the cycle after the last write. `busy` stays 1 from the first read through the `start_exec` cycle.
- R6: `start_exec` is a single-cycle pulse in the cycle after `irq`. It is issued once per completed copy, and it grants the processor instruction fetch from local address 0.
- R7: `done` becomes 1 in the cycle after `start_exec`. It stays 1 until `cpu_hold` is asserted again or `rst_n` goes low.
- R8: Asserting `cpu_hold` during the copy, the `irq` cycle or the start cycle aborts the boot. Reads, writes, `busy` and the pending strobes drop in that same cycle, and neither `irq` nor `start_exec` follows.
- R9: After an abort, the next release restarts the copy from buffer address 0 and completes normally.
- R10: `rst_n` low at any time returns the block to idle with all outputs 0. A boot in progress is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| cpu_hold | input | 1 | 1 while the I/O processor is held in reset |
| buf_rd_en | output | 1 | Buffer memory read request |
| buf_rd_addr | output | AW | Buffer memory word address |
| buf_rd_data | input | DW | Buffer read data, valid the cycle after the request |
| loc_wr_en | output | 1 | Local memory write strobe |
| loc_wr_addr | output | AW | Local memory word address |
| loc_wr_data | output | DW | Local memory write data |
| busy | output | 1 | Boot in progress |
| done | output | 1 | Boot completed and processor started |
| irq | output | 1 | Copy-complete interrupt pulse |
| start_exec | output | 1 | Start strobe: processor fetches from address 0 |

## Verification
Embedded assertions check on every cycle that:
- nothing moves while the processor is held in reset;
- every write follows a read of the same address one cycle earlier;
- consecutive writes climb by one address;
- the interrupt is a lone pulse followed by the start strobe;
- the start strobe is always preceded by the interrupt;
- `done` persists.

Only the directed scenarios can show the rest:
- the data of each word matches the source;
- the total word count and the exact cycle of each output relative to the release;
- that aborts during the copy or in the interrupt cycle suppress the start strobe;
- that a later release restarts cleanly from address 0 after a hold or a chip reset.

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_hold,
  output logic          buf_rd_en,
  output logic [AW-1:0] buf_rd_addr,
  input  logic [DW-1:0] buf_rd_data,
  output logic          loc_wr_en,
  output logic [AW-1:0] loc_wr_addr,
  output logic [DW-1:0] loc_wr_data,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          start_exec
);

  localparam logic [AW-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_COPY, S_IRQ, S_GO, S_DONE} state_t;

  state_t        st;
  logic          hold_q;
  logic          rd_fin;
  logic          wr_pend;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] wr_ptr;

  wire release_ev = hold_q && !cpu_hold;

  assign buf_rd_en   = (st == S_COPY) && !rd_fin && !cpu_hold;
  assign buf_rd_addr = rd_ptr;
  assign loc_wr_en   = (st == S_COPY) && wr_pend && !cpu_hold;
  assign loc_wr_addr = wr_ptr;
  assign loc_wr_data = buf_rd_data;
  assign irq         = (st == S_IRQ) && !cpu_hold;
  assign start_exec  = (st == S_GO) && !cpu_hold;
  assign busy        = (st == S_COPY || st == S_IRQ || st == S_GO) && !cpu_hold;
  assign done        = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hold_q  <= 1'b1;
      rd_fin  <= 1'b0;
      wr_pend <= 1'b0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
    end else begin
      hold_q <= cpu_hold;
      if (cpu_hold) begin
        st      <= S_IDLE;
        rd_fin  <= 1'b0;
        wr_pend <= 1'b0;
        rd_ptr  <= '0;
      end else begin
        case (st)
          S_IDLE: if (release_ev) begin
            st      <= S_COPY;
            rd_ptr  <= '0;
            rd_fin  <= 1'b0;
            wr_pend <= 1'b0;
          end
          S_COPY: begin
            wr_pend <= buf_rd_en;
            if (buf_rd_en) begin
              wr_ptr <= rd_ptr;
              rd_ptr <= rd_ptr + 1'b1;
              if (rd_ptr == LAST) rd_fin <= 1'b1;
            end
            if (wr_pend && wr_ptr == LAST) st <= S_IRQ;
          end
          S_IRQ:   st <= S_GO;
          S_GO:    st <= S_DONE;
          default: st <= st;
        endcase
      end
    end
  end

  assert_quiet_in_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_hold) |-> (!busy && !done && !irq && !start_exec));

  assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en |-> ($past(buf_rd_en) && loc_wr_addr == $past(buf_rd_addr)));

  assert_ascending_writes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_wr_en && $past(loc_wr_en)) |-> (loc_wr_addr == $past(loc_wr_addr) + 1'b1));

  assert_irq_then_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq && (start_exec || cpu_hold)));

  assert_start_after_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_exec |-> $past(irq));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cpu_hold) |=> done);

endmodule

// File: tb/boot_loader_bench.sv
`timescale 1ns/1ps
module boot_loader_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_hold = 1'b1;
  logic          buf_rd_en, loc_wr_en, busy, done, irq, start_exec;
  logic [AW-1:0] buf_rd_addr, loc_wr_addr;
  logic [DW-1:0] buf_rd_data, loc_wr_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  int cyc = 0, wr_cnt = 0, rd_cnt = 0, wr_err = 0, exp_addr = 0;
  int irq_cnt = 0, st_cnt = 0, first_rd = -1, first_wr = -1, last_wr = -1;
  int irq_cyc = -1, st_cyc = -1;

  always #2.5 clk = ~clk;

  boot_loader #(.AW(AW), .DW(DW)) u_boot_loader (
    .clk(clk), .rst_n(rst_n), .cpu_hold(cpu_hold),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
    .busy(busy), .done(done), .irq(irq), .start_exec(start_exec)
  );

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 40503 + 4660) ^ (a >> 3));
  endfunction

  always @(posedge clk) if (buf_rd_en) buf_rd_data <= pat(int'(buf_rd_addr));

  always @(negedge clk) begin
    if (buf_rd_en) begin
      if (rd_cnt == 0) first_rd = cyc;
      rd_cnt++;
    end
    if (loc_wr_en) begin
      if (int'(loc_wr_addr) != exp_addr || loc_wr_data != pat(int'(loc_wr_addr))) wr_err++;
      if (wr_cnt == 0) first_wr = cyc;
      last_wr = cyc;
      exp_addr++;
      wr_cnt++;
    end
    if (irq) begin irq_cnt++; irq_cyc = cyc; end
    if (start_exec) begin st_cnt++; st_cyc = cyc; end
    cyc++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_cnt = 0; rd_cnt = 0; wr_err = 0; exp_addr = 0; irq_cnt = 0; st_cnt = 0;
    first_rd = -1; first_wr = -1; last_wr = -1; irq_cyc = -1; st_cyc = -1;
  endtask

  // Releases by dropping cpu_hold (use_rst=0) or by lifting rst_n with hold low (use_rst=1)
  task automatic full_boot(input bit use_rst, input string tag);
    int c0;
    @(posedge clk); #1;
    clear_mon();
    c0 = cyc;
    if (use_rst) rst_n = 1'b1; else cpu_hold = 1'b0;
    @(posedge clk); #1;
    chk(busy == 1'b1, {tag, " R2 busy after release"}, busy, 1);
    repeat (N + 8) @(posedge clk);
    #1;
    chk(first_rd == c0 + 1, {tag, " R2 first read cycle"}, first_rd - c0, 1);
    chk(wr_cnt == N, {tag, " R3 word count"}, wr_cnt, N);
    chk(wr_err == 0, {tag, " R3 address/data mismatches"}, wr_err, 0);
    chk(first_wr == c0 + 2 && last_wr == c0 + N + 1, {tag, " R4 write window"},
        last_wr - first_wr + 1, N);
    chk(irq_cnt == 1 && irq_cyc == last_wr + 1, {tag, " R5 irq after last write"},
        irq_cyc - last_wr, 1);
    chk(st_cnt == 1 && st_cyc == irq_cyc + 1, {tag, " R6 start after irq"},
        st_cyc - irq_cyc, 1);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R7 done set, busy clear"}, {done, busy}, 2);
  endtask

  task automatic t_reset_state();
    repeat (3) @(posedge clk);
    #1;
    chk({buf_rd_en, loc_wr_en, busy, done, irq, start_exec} == 6'b0, "R10 outputs in reset",
        {buf_rd_en, loc_wr_en, busy, done, irq, start_exec}, 0);
    rst_n = 1'b1;
    clear_mon();
    repeat (30) @(posedge clk);
    #1;
    chk(rd_cnt == 0 && wr_cnt == 0 && busy == 1'b0 && done == 1'b0, "R1 idle while held",
        rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_boot_and_done();
    full_boot(1'b0, "boot");
    repeat (40) @(posedge clk);
    #1;
    chk(done == 1'b1 && wr_cnt == N && st_cnt == 1, "R7 done persists, no more activity",
        done, 1);
    cpu_hold = 1'b1;
    @(posedge clk); #1;
    chk(done == 1'b0, "R7 done cleared by hold", done, 0);
  endtask

  task automatic t_abort_copy();
    int w;
    @(posedge clk); #1;
    clear_mon();
    cpu_hold = 1'b0;
    repeat (100) @(posedge clk);
    #1;
    cpu_hold = 1'b1;
    #0.5;
    chk(busy == 1'b0 && loc_wr_en == 1'b0 && buf_rd_en == 1'b0, "R8 same-cycle drop",
        {busy, loc_wr_en, buf_rd_en}, 0);
    @(negedge clk);
    w = wr_cnt;
    repeat (N + 8) @(posedge clk);
    #1;
    chk(wr_cnt == w && w < N, "R8 no writes after abort", wr_cnt, w);
    chk(irq_cnt == 0 && st_cnt == 0 && done == 1'b0, "R8 no irq/start after abort",
        irq_cnt + st_cnt, 0);
    full_boot(1'b0, "restart R9");
    cpu_hold = 1'b1;
  endtask

  task automatic t_abort_in_irq();
    @(posedge clk); #1;
    clear_mon();
    cpu_hold = 1'b0;
    do @(negedge clk); while (!irq);
    #1;
    cpu_hold = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(st_cnt == 0 && done == 1'b0, "R8 abort in irq cycle suppresses start", st_cnt, 0);
  endtask

  task automatic t_chip_reset();
    @(posedge clk); #1;
    cpu_hold = 1'b0;
    repeat (50) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    chk({buf_rd_en, loc_wr_en, busy, done, irq, start_exec} == 6'b0, "R10 reset mid copy",
        {buf_rd_en, loc_wr_en, busy, done, irq, start_exec}, 0);
    repeat (3) @(posedge clk);
    full_boot(1'b1, "post-reset R10");
  endtask

  initial begin
    t_reset_state();
    t_boot_and_done();
    t_abort_copy();
    t_abort_in_irq();
    t_chip_reset();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #250000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule